// File: doc/BRIEF.md
# SMBus Target Byte Register Port

This block is the target side of a two-wire SMBus link. It runs on the system clock and oversamples SCL and SDA through synchronisers. It answers to one 7-bit device address, which comes out of reset at a nonzero value (0x44). Software may load a new address through a one-cycle write port, and the new value applies from the next transaction. The block drives SDA low only to acknowledge a byte or to send a zero data bit. It never holds SCL low, and it neither checks nor sends a packet error code.

Two transactions are understood: a single-byte write and a single-byte read. A write carries a command code and a data byte. The block presents them to an external register file as an address, a data value and a one-cycle write strobe. A read carries a command code, then a repeated Start and the address again. The block then fetches one byte from the register file's combinational read port and shifts it out MSB first. Once the address matches, the direction bit is not consulted in either address phase: the order of the frame alone decides write or read.

Top module: `smb_byte_port`

## Requirements
- R1: During and right after reset, `sda_drive_low_o`, `rf_wr_stb_o` and `rf_rd_stb_o` are 0. The device address is 0x44.
- R2: A one-cycle pulse on `own_addr_we_i` replaces the device address with `own_addr_wd_i`. From then on only the new address is acknowledged.
- R3: If the seven address bits of a first address byte (the upper seven bits, sent MSB first) do not match, no ACK is given. No later byte is acknowledged and no strobe fires until the next Start.
- R4: In the first address phase the R/W bit (the last bit of the address byte) is ignored. A matching address with R/W = 1 is acknowledged and treated as a write-type first phase.
- R5: A write is Start, address, ACK, command, ACK, data, ACK, Stop. The target acknowledges all three bytes. After the data ACK clock ends, `rf_wr_stb_o` is high for exactly one clock, with `rf_addr_o` = command and `rf_wr_data_o` = data.
- R6: A read is Start, address, ACK, command, ACK, repeated Start, address, ACK, 8 data bits, master ACK/NACK, Stop. On a match in the second address phase, `rf_rd_stb_o` pulses once, `rf_rd_data_i` at `rf_addr_o` = command is captured, and the byte is driven MSB first.
- R7: In the repeated-start address phase the R/W bit is ignored. A matching address with R/W = 0 still yields a read. A non-matching address gets no ACK and no data.
- R8: The target changes SDA only while SCL is low. Start is SDA falling while SCL is high. Stop is SDA rising while SCL is high.
- R9: A Start in any state, including partway through a byte, restarts address reception.
- R10: A Stop in any state returns the engine to idle with SDA released. A write that stops before its data byte produces no strobe.
- R11: Only one data byte is returned per read. After it the target releases SDA whatever the master answers, and it drives no further bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level (wired bus value) |
| sda_drive_low_o | output | 1 | 1 = pull SDA low (open-drain enable) |
| own_addr_we_i | input | 1 | Load strobe for the device address |
| own_addr_wd_i | input | 7 | New device address |
| rf_addr_o | output | 8 | Register-file address (last command code) |
| rf_wr_data_o | output | 8 | Register-file write data |
| rf_wr_stb_o | output | 1 | One-cycle register-file write strobe |
| rf_rd_data_i | input | 8 | Register-file read data at `rf_addr_o` |
| rf_rd_stb_o | output | 1 | One-cycle pulse when read data is captured |

## Verification
The bench targets three groups of cases.

The first is the direction bit. It is set to read in the first phase and to write in the repeated-start phase. A design that honoured the bit would NACK the first case or return nothing in the second.

The second is flow control. A Start arrives after four bits of an address byte, and a Stop follows straight after the command ACK. A design that kept its bit count across the Start would shift the frame and miss the address. A design that strobed too early would write a stale data byte.

The third is the address and the end of a read. The address is reprogrammed, a wrong address is sent, and the master ACKs the read byte and clocks a second one. A wrong design would acknowledge the old or foreign address, write on it, or keep driving bits past the single byte.

// File: rtl/smb_port_pkg.sv
`timescale 1ns/1ps
package smb_port_pkg;
    localparam int BYTE_W     = 8;
    localparam int DEV_ADDR_W = 7;
    localparam int BIT_CNT_W  = $clog2(BYTE_W + 1);

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_CMD,
        ST_CMD_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RADDR,
        ST_RADDR_ACK,
        ST_RDATA,
        ST_MACK,
        ST_WAIT_STOP
    } phase_e;

    typedef struct packed {
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_ev_t;

    function automatic logic addr_hit(input logic [BYTE_W-1:0] rx,
                                      input logic [DEV_ADDR_W-1:0] own);
        return rx[BYTE_W-1:1] == own;
    endfunction

    function automatic logic is_ack_phase(input phase_e p);
        return (p == ST_ADDR_ACK) || (p == ST_CMD_ACK) ||
               (p == ST_WDATA_ACK) || (p == ST_RADDR_ACK);
    endfunction
endpackage

// File: rtl/smb_line_sync.sv
`timescale 1ns/1ps
module smb_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic q
);
    logic [STAGES-1:0] pipe_q;

    always_ff @(posedge clk) begin
        if (rst) pipe_q <= '1;
        else     pipe_q <= {pipe_q[STAGES-2:0], din};
    end

    assign q = pipe_q[STAGES-1];
endmodule

// File: rtl/smb_bus_events.sv
`timescale 1ns/1ps
module smb_bus_events
    import smb_port_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_s,
    input  logic    sda_s,
    output bus_ev_t ev
);
    logic scl_prev_q, sda_prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_prev_q <= 1'b1;
            sda_prev_q <= 1'b1;
        end else begin
            scl_prev_q <= scl_s;
            sda_prev_q <= sda_s;
        end
    end

    always_comb begin
        ev.sda      = sda_s;
        ev.scl_rise = scl_s & ~scl_prev_q;
        ev.scl_fall = ~scl_s & scl_prev_q;
        ev.start    = scl_s & scl_prev_q & sda_prev_q & ~sda_s;
        ev.stop     = scl_s & scl_prev_q & ~sda_prev_q & sda_s;
    end
endmodule

// File: rtl/smb_addr_reg.sv
`timescale 1ns/1ps
module smb_addr_reg
    import smb_port_pkg::*;
#(
    parameter logic [DEV_ADDR_W-1:0] RESET_ADDR = 7'h44
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  we,
    input  logic [DEV_ADDR_W-1:0] wd,
    output logic [DEV_ADDR_W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)     q <= RESET_ADDR;
        else if (we) q <= wd;
    end
endmodule

// File: rtl/smb_frame_fsm.sv
`timescale 1ns/1ps
module smb_frame_fsm
    import smb_port_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  bus_ev_t               ev,
    input  logic [DEV_ADDR_W-1:0] own_addr,
    input  logic [BYTE_W-1:0]     rd_data,
    output logic                  drive_low,
    output logic [BYTE_W-1:0]     cmd,
    output logic [BYTE_W-1:0]     wr_data,
    output logic                  wr_stb,
    output logic                  rd_stb
);
    localparam logic [BIT_CNT_W-1:0] CNT_FULL = BIT_CNT_W'(BYTE_W);
    localparam logic [BIT_CNT_W-1:0] CNT_LAST = BIT_CNT_W'(BYTE_W - 1);
    localparam logic [BIT_CNT_W-1:0] CNT_ONE  = BIT_CNT_W'(1);

    phase_e               phase_q;
    logic [BIT_CNT_W-1:0] cnt_q;
    logic [BYTE_W-1:0]    shreg_q, tx_q;
    logic                 cmd_seen_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q    <= ST_IDLE;
            cnt_q      <= '0;
            shreg_q    <= '0;
            tx_q       <= '0;
            cmd_seen_q <= 1'b0;
            cmd        <= '0;
            wr_data    <= '0;
            wr_stb     <= 1'b0;
            rd_stb     <= 1'b0;
        end else begin
            wr_stb <= 1'b0;
            rd_stb <= 1'b0;
            if (ev.stop) begin
                phase_q    <= ST_IDLE;
                cmd_seen_q <= 1'b0;
            end else if (ev.start) begin
                // a Start after an acknowledged command opens the read phase
                phase_q <= cmd_seen_q ? ST_RADDR : ST_ADDR;
                cnt_q   <= '0;
                shreg_q <= '0;
            end else begin
                case (phase_q)
                    ST_ADDR, ST_CMD, ST_WDATA, ST_RADDR: begin
                        if (ev.scl_rise) begin
                            shreg_q <= {shreg_q[BYTE_W-2:0], ev.sda};
                            cnt_q   <= cnt_q + CNT_ONE;
                        end else if (ev.scl_fall && cnt_q == CNT_FULL) begin
                            cnt_q <= '0;
                            if (phase_q == ST_ADDR) begin
                                // direction bit deliberately not examined
                                phase_q <= addr_hit(shreg_q, own_addr) ? ST_ADDR_ACK : ST_IDLE;
                            end else if (phase_q == ST_CMD) begin
                                cmd     <= shreg_q;
                                phase_q <= ST_CMD_ACK;
                            end else if (phase_q == ST_WDATA) begin
                                wr_data <= shreg_q;
                                phase_q <= ST_WDATA_ACK;
                            end else if (addr_hit(shreg_q, own_addr)) begin
                                tx_q    <= rd_data;
                                rd_stb  <= 1'b1;
                                phase_q <= ST_RADDR_ACK;
                            end else begin
                                phase_q    <= ST_IDLE;
                                cmd_seen_q <= 1'b0;
                            end
                        end
                    end
                    ST_ADDR_ACK: if (ev.scl_fall) phase_q <= ST_CMD;
                    ST_CMD_ACK: if (ev.scl_fall) begin
                        phase_q    <= ST_WDATA;
                        cmd_seen_q <= 1'b1;
                    end
                    ST_WDATA_ACK: if (ev.scl_fall) begin
                        wr_stb     <= 1'b1;
                        cmd_seen_q <= 1'b0;
                        phase_q    <= ST_WAIT_STOP;
                    end
                    ST_RADDR_ACK: if (ev.scl_fall) begin
                        phase_q <= ST_RDATA;
                        cnt_q   <= '0;
                    end
                    ST_RDATA: if (ev.scl_fall) begin
                        if (cnt_q == CNT_LAST) begin
                            phase_q <= ST_MACK;
                        end else begin
                            cnt_q <= cnt_q + CNT_ONE;
                            tx_q  <= {tx_q[BYTE_W-2:0], 1'b0};
                        end
                    end
                    ST_MACK: if (ev.scl_fall) begin
                        phase_q    <= ST_WAIT_STOP;
                        cmd_seen_q <= 1'b0;
                    end
                    default: ;
                endcase
            end
        end
    end

    assign drive_low = is_ack_phase(phase_q) ||
                       ((phase_q == ST_RDATA) && !tx_q[BYTE_W-1]);
endmodule

// File: rtl/smb_byte_port.sv
`timescale 1ns/1ps
module smb_byte_port
    import smb_port_pkg::*;
#(
    parameter int                    SYNC_STAGES = 2,
    parameter logic [DEV_ADDR_W-1:0] RESET_ADDR  = 7'h44
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  scl_i,
    input  logic                  sda_i,
    output logic                  sda_drive_low_o,
    input  logic                  own_addr_we_i,
    input  logic [DEV_ADDR_W-1:0] own_addr_wd_i,
    output logic [BYTE_W-1:0]     rf_addr_o,
    output logic [BYTE_W-1:0]     rf_wr_data_o,
    output logic                  rf_wr_stb_o,
    input  logic [BYTE_W-1:0]     rf_rd_data_i,
    output logic                  rf_rd_stb_o
);
    localparam int N_LINES = 2;

    logic [N_LINES-1:0]    line_raw, line_s;
    logic                  scl_s, sda_s;
    bus_ev_t               bus_ev;
    logic [DEV_ADDR_W-1:0] own_addr;

    assign line_raw = {scl_i, sda_i};

    for (genvar g = 0; g < N_LINES; g++) begin : g_sync
        smb_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk (clk),
            .rst (rst),
            .din (line_raw[g]),
            .q   (line_s[g])
        );
    end

    assign scl_s = line_s[1];
    assign sda_s = line_s[0];

    smb_bus_events u_events (
        .clk   (clk),
        .rst   (rst),
        .scl_s (scl_s),
        .sda_s (sda_s),
        .ev    (bus_ev)
    );

    smb_addr_reg #(.RESET_ADDR(RESET_ADDR)) u_addr (
        .clk (clk),
        .rst (rst),
        .we  (own_addr_we_i),
        .wd  (own_addr_wd_i),
        .q   (own_addr)
    );

    smb_frame_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .ev        (bus_ev),
        .own_addr  (own_addr),
        .rd_data   (rf_rd_data_i),
        .drive_low (sda_drive_low_o),
        .cmd       (rf_addr_o),
        .wr_data   (rf_wr_data_o),
        .wr_stb    (rf_wr_stb_o),
        .rd_stb    (rf_rd_stb_o)
    );
endmodule

// File: rtl/smb_byte_port_chk.sv
`timescale 1ns/1ps
module smb_byte_port_chk (
    input logic clk,
    input logic rst,
    input logic scl_s,
    input logic stop_ev,
    input logic sda_drive_low,
    input logic rf_wr_stb,
    input logic rf_rd_stb
);
    // R1: outputs quiet right after reset
    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> (!sda_drive_low && !rf_wr_stb && !rf_rd_stb));

    // R8: the target alters SDA only while the synchronised SCL is low
    p_sda_change_scl_low_r8: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_drive_low) |-> !scl_s);

    // R5: a write strobe follows an acknowledge and lasts one clock
    p_wr_after_ack_r5: assert property (@(posedge clk) disable iff (rst)
        rf_wr_stb |-> $past(sda_drive_low));
    p_wr_single_r5: assert property (@(posedge clk) disable iff (rst)
        rf_wr_stb |=> !rf_wr_stb);

    // R6: a read capture is followed by the address acknowledge
    p_rd_then_ack_r6: assert property (@(posedge clk) disable iff (rst)
        rf_rd_stb |=> sda_drive_low);

    // R10: a Stop leaves SDA released
    p_stop_release_r10: assert property (@(posedge clk) disable iff (rst)
        stop_ev |=> !sda_drive_low);
endmodule

bind smb_byte_port smb_byte_port_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .scl_s         (scl_s),
    .stop_ev       (bus_ev.stop),
    .sda_drive_low (sda_drive_low_o),
    .rf_wr_stb     (rf_wr_stb_o),
    .rf_rd_stb     (rf_rd_stb_o)
);

// File: tb/smb_byte_port_tb.sv
`timescale 1ns/1ps
module smb_byte_port_tb;
    localparam int Q = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic sda_drive_low;
    logic own_addr_we = 1'b0;
    logic [6:0] own_addr_wd = '0;
    logic [7:0] rf_addr, rf_wr_data, rf_rd_data;
    logic rf_wr_stb, rf_rd_stb;
    logic sda_bus;

    int n_vec = 0;
    int n_bad = 0;
    int rd_cnt = 0;
    logic [6:0] cur_addr = 7'h44;

    logic [7:0] rf_mem  [256];
    logic [7:0] exp_mem [256];

    typedef struct packed { logic [7:0] a; logic [7:0] d; } wr_t;
    wr_t wq[$];

    always #2.5 clk = ~clk;

    assign sda_bus    = m_sda & ~sda_drive_low;
    assign rf_rd_data = rf_mem[rf_addr];

    smb_byte_port u_dut (
        .clk             (clk),
        .rst             (rst),
        .scl_i           (m_scl),
        .sda_i           (sda_bus),
        .sda_drive_low_o (sda_drive_low),
        .own_addr_we_i   (own_addr_we),
        .own_addr_wd_i   (own_addr_wd),
        .rf_addr_o       (rf_addr),
        .rf_wr_data_o    (rf_wr_data),
        .rf_wr_stb_o     (rf_wr_stb),
        .rf_rd_data_i    (rf_rd_data),
        .rf_rd_stb_o     (rf_rd_stb)
    );

    always @(posedge clk) if (rf_wr_stb) rf_mem[rf_addr] <= rf_wr_data;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // per-clock comparison of write strobes against the expected-write queue (R5)
    always @(negedge clk) begin
        if (!rst && rf_rd_stb) rd_cnt++;
        if (!rst && rf_wr_stb) begin
            if (wq.size() == 0) begin
                chk("R5 unexpected strobe", 1, 0);
            end else begin
                wr_t e;
                e = wq.pop_front();
                chk("R5 strobe addr/data", {rf_addr, rf_wr_data}, {e.a, e.d});
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; tick(Q);
        m_scl = 1'b1; tick(Q);
        m_sda = 1'b0; tick(Q);
        m_scl = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; tick(Q);
        m_scl = 1'b1; tick(Q);
        m_sda = 1'b1; tick(Q);
    endtask

    task automatic clock_bit(input logic b, output logic s);
        m_sda = b;    tick(Q);
        m_scl = 1'b1; tick(Q);
        s = sda_bus;  tick(Q);
        m_scl = 1'b0; tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        logic s;
        for (int i = 7; i >= 0; i--) clock_bit(b[i], s);
        clock_bit(1'b1, s);
        acked = ~s;
    endtask

    task automatic recv_byte(output logic [7:0] b, input logic master_ack);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            clock_bit(1'b1, s);
            b[i] = s;
        end
        clock_bit(~master_ack, s);
    endtask

    task automatic set_addr(input logic [6:0] a);
        own_addr_wd = a;
        own_addr_we = 1'b1; tick(1);
        own_addr_we = 1'b0; tick(1);
        cur_addr = a;
    endtask

    task automatic do_write(input string req, input logic [6:0] a, input logic rw,
                            input logic [7:0] c, input logic [7:0] d);
        logic k0, k1, k2, hit;
        hit = (a == cur_addr);
        bus_start();
        send_byte({a, rw}, k0);
        send_byte(c, k1);
        if (hit) begin
            wr_t e;
            e.a = c; e.d = d;
            wq.push_back(e);
            exp_mem[c] = d;
        end
        send_byte(d, k2);
        bus_stop();
        tick(4);
        chk({req, " addr ack"}, k0, hit);
        chk({req, " cmd ack"},  k1, hit);
        chk({req, " data ack"}, k2, hit);
        chk({req, " strobe drained"}, wq.size(), 0);
    endtask

    task automatic do_read(input string req, input logic [6:0] a1, input logic [6:0] a2,
                           input logic rw2, input logic [7:0] c);
        logic k0, k1, k2, hit;
        logic [7:0] got, exp;
        int rd0;
        rd0 = rd_cnt;
        hit = (a1 == cur_addr) && (a2 == cur_addr);
        exp = hit ? exp_mem[c] : 8'hFF;
        bus_start();
        send_byte({a1, 1'b0}, k0);
        send_byte(c, k1);
        bus_start();
        send_byte({a2, rw2}, k2);
        recv_byte(got, 1'b0);
        bus_stop();
        tick(4);
        chk({req, " raddr ack"}, k2, hit);
        chk({req, " data"}, got, exp);
        chk({req, " rd strobe count"}, rd_cnt - rd0, hit ? 1 : 0);
        chk({req, " released after stop"}, sda_drive_low, 0);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) begin
            rf_mem[i]  = 8'(i) ^ 8'h3C;
            exp_mem[i] = 8'(i) ^ 8'h3C;
        end
        tick(3);
        chk("R1 drive after reset", sda_drive_low, 0);
        chk("R1 wr strobe after reset", rf_wr_stb, 0);
        chk("R1 rd strobe after reset", rf_rd_stb, 0);
        rst = 1'b0;
        tick(10);

        // R5 / R1: write at the reset address, read back (R6)
        do_write("R5 write default addr", 7'h44, 1'b0, 8'h10, 8'hA5);
        do_read("R6 read back", 7'h44, 7'h44, 1'b1, 8'h10);
        do_write("R5 write zeros", 7'h44, 1'b0, 8'h81, 8'h00);
        do_read("R6 read zeros", 7'h44, 7'h44, 1'b1, 8'h81);
        do_write("R5 write ones", 7'h44, 1'b0, 8'hFF, 8'hFF);
        do_read("R6 read ones", 7'h44, 7'h44, 1'b1, 8'hFF);
        do_read("R6 read untouched", 7'h44, 7'h44, 1'b1, 8'h5A);

        // R4: read direction in the first phase still claims a write
        do_write("R4 rw=1 first phase", 7'h44, 1'b1, 8'h22, 8'h96);
        do_read("R4 check value", 7'h44, 7'h44, 1'b1, 8'h22);

        // R7: write direction in the repeated-start phase still reads
        do_read("R7 rw=0 second phase", 7'h44, 7'h44, 1'b0, 8'h22);
        // R7: mismatching repeated-start address: no ack, no data
        do_read("R7 second addr mismatch", 7'h44, 7'h45, 1'b1, 8'h22);

        // R3: foreign address ignored entirely
        do_write("R3 foreign addr", 7'h13, 1'b0, 8'h10, 8'h77);
        do_read("R3 value kept", 7'h44, 7'h44, 1'b1, 8'h10);

        // R2: reprogram the address
        set_addr(7'h2B);
        do_write("R2 old addr refused", 7'h44, 1'b0, 8'h30, 8'h11);
        do_write("R2 new addr", 7'h2B, 1'b0, 8'h30, 8'hC3);
        do_read("R2 read new addr", 7'h2B, 7'h2B, 1'b1, 8'h30);
        set_addr(7'h44);

        // R9: Start after four address bits restarts reception
        begin
            logic s;
            bus_start();
            for (int i = 0; i < 4; i++) clock_bit(1'b0, s);
            do_write("R9 start mid-byte", 7'h44, 1'b0, 8'h40, 8'h3E);
        end

        // R10: Stop right after the command: no strobe, value unchanged
        begin
            logic k0, k1;
            bus_start();
            send_byte({7'h44, 1'b0}, k0);
            send_byte(8'h41, k1);
            bus_stop();
            tick(4);
            chk("R10 cmd ack before stop", k1, 1);
            chk("R10 no strobe", wq.size(), 0);
            chk("R10 released", sda_drive_low, 0);
            do_read("R10 value unchanged", 7'h44, 7'h44, 1'b1, 8'h41);
        end

        // R11: master ACKs the byte and clocks another: target stays silent
        begin
            logic k0, k1, k2;
            logic [7:0] b1, b2;
            bus_start();
            send_byte({7'h44, 1'b0}, k0);
            send_byte(8'h10, k1);
            bus_start();
            send_byte({7'h44, 1'b1}, k2);
            recv_byte(b1, 1'b1);
            recv_byte(b2, 1'b0);
            bus_stop();
            tick(4);
            chk("R11 first byte", b1, exp_mem[8'h10]);
            chk("R11 no second byte", b2, 8'hFF);
        end

        tick(20);
        chk("R5 queue empty at end", wq.size(), 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule